// File: doc/BRIEF.md
# Multi-mode eight-bit addressable latch

This block holds eight single-bit storage cells that share one serial data input and a three-bit select. Two active-LOW controls, a write strobe and a conditional clear, put the same cells into one of four modes. In write mode only the selected cell takes the data. In hold mode nothing changes. In decode mode the selected cell takes the data and every other cell is cleared. In clear mode all cells go LOW. With the data input tied HIGH, decode mode acts as an active-HIGH 3-to-8 decoder. Writing one bit at a time to successive selects turns a serial stream into a parallel word.

Storage updates on the rising clock edge. The output path is combinational from the present inputs, so a cell being written shows the incoming data in the same cycle, and a cell being forced LOW shows LOW in the same cycle. A cell that is not touched by the current mode shows its stored value. An asynchronous active-LOW reset clears all cells for the clock domain. This reset is separate from the functional clear input.

Top module: `addr_latch8`

## Requirements
- R1: With wr_n=0 and clr_n=1, bits_o[sel] equals din in the same cycle, and every other output bit keeps its value from before that cycle.
- R2: With wr_n=1 and clr_n=1, bits_o equals the stored word and does not depend on din or sel.
- R3: With wr_n=0 and clr_n=0, bits_o[sel] equals din and all other output bits are 0.
- R4: With wr_n=1 and clr_n=0, bits_o is all zeros whatever din and sel are.
- R5: sel is binary with sel[0] as the least significant bit, and the value n selects bits_o[n] for n from 0 to 7.
- R6: After a write cycle, the cell keeps the din value that was present at the last rising clock edge with wr_n=0, even when din changes afterwards in hold mode.
- R7: A clear sampled at a clock edge is stored, so the outputs stay 0 after the block goes back to hold mode.
- R8: A decode cycle sampled at a clock edge stores its one-hot pattern, and hold mode shows that pattern afterwards.
- R9: Eight write cycles to selects 0 through 7 followed by hold show the written bits on bits_o[0] through bits_o[7].
- R10: rst_n=0 clears every cell at once, with no clock edge needed. After release, hold mode shows all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-LOW reset, released synchronously |
| din | input | 1 | Serial data bit |
| sel | input | 3 | Cell select, bit 0 least significant |
| wr_n | input | 1 | Active-LOW write strobe |
| clr_n | input | 1 | Active-LOW conditional clear |
| bits_o | output | 8 | Parallel cell outputs |

## Verification
Mode results on bits_o are combinational, so they are due in the same cycle as the stimulus. Stored effects (R6 to R9) are due one rising edge later. The bench drives inputs on the falling edge and compares bits_o a few nanoseconds later, still before the next rising edge. It keeps its own copy of the stored word and updates that copy only at the rising edge, which means each stored effect is checked in the cycle after the stimulus that caused it. The asynchronous reset is checked two nanoseconds after it is asserted, with no clock edge in between.

// File: rtl/addr_latch8_pkg.sv
package addr_latch8_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } latch_mode_e;

  function automatic latch_mode_e mode_of(input logic wr_n, input logic clr_n);
    latch_mode_e m;
    case ({clr_n, wr_n})
      2'b10:   m = MODE_WRITE;
      2'b11:   m = MODE_HOLD;
      2'b00:   m = MODE_DEMUX;
      default: m = MODE_CLEAR;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/al_mode_dec.sv
module al_mode_dec
  import addr_latch8_pkg::*;
(
  input  logic        wr_n,
  input  logic        clr_n,
  output latch_mode_e mode
);

  always_comb begin
    mode = mode_of(wr_n, clr_n);
  end

endmodule

// File: rtl/al_sel_dec.sv
module al_sel_dec #(
  parameter int NBITS = 8,
  localparam int AW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic [AW-1:0]    sel,
  output logic [NBITS-1:0] hit
);

  for (genvar i = 0; i < NBITS; i++) begin : g_hit
    localparam logic [AW-1:0] IDX = AW'(i);
    assign hit[i] = (sel == IDX);
  end

  // R5
  sel_onehot_chk: assert final ($onehot(hit));

endmodule

// File: rtl/al_cell_next.sv
module al_cell_next
  import addr_latch8_pkg::*;
(
  input  latch_mode_e mode,
  input  logic        hit,
  input  logic        din,
  input  logic        cur,
  output logic        nxt
);

  always_comb begin
    unique case (mode)
      MODE_WRITE: nxt = hit ? din : cur;
      MODE_HOLD:  nxt = cur;
      MODE_DEMUX: nxt = hit & din;
      MODE_CLEAR: nxt = 1'b0;
      default:    nxt = 1'b0;
    endcase
  end

endmodule

// File: rtl/al_store.sv
module al_store #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NBITS-1:0] d_next,
  output logic [NBITS-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= d_next;
    end
  end

endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
  import addr_latch8_pkg::*;
#(
  parameter int NBITS = 8,
  localparam int AW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [AW-1:0]    sel,
  input  logic             wr_n,
  input  logic             clr_n,
  output logic [NBITS-1:0] bits_o
);

  latch_mode_e      mode;
  logic [NBITS-1:0] hit;
  logic [NBITS-1:0] cell_q;
  logic [NBITS-1:0] cell_d;
  logic             store_en;

  al_mode_dec u_mode (
    .wr_n  (wr_n),
    .clr_n (clr_n),
    .mode  (mode)
  );

  al_sel_dec #(.NBITS(NBITS)) u_sel (
    .sel (sel),
    .hit (hit)
  );

  for (genvar i = 0; i < NBITS; i++) begin : g_cell
    al_cell_next u_next (
      .mode (mode),
      .hit  (hit[i]),
      .din  (din),
      .cur  (cell_q[i]),
      .nxt  (cell_d[i])
    );
  end

  // Clock enable written out: hold mode leaves the cells untouched.
  assign store_en = (mode != MODE_HOLD);

  al_store #(.NBITS(NBITS)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (store_en),
    .d_next (cell_d),
    .q      (cell_q)
  );

  // Combinational output path: data passes through the write and decode
  // modes in the same cycle, and the clear mode forces LOW in the same cycle.
  assign bits_o = cell_d;

  // A cycle since reset has completed, so the previous output was committed.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
    end
  end

  // R1
  write_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !wr_n && clr_n) |-> (((bits_o ^ $past(bits_o)) & ~hit) == '0));

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_n && clr_n) |-> (bits_o == $past(bits_o)));

  // R3
  demux_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !clr_n) |-> ($onehot0(bits_o) && ((bits_o & ~hit) == '0)));

  // R4
  clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n && !clr_n) |-> (bits_o == '0));

  // R7
  clear_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(wr_n && !clr_n) && wr_n && clr_n) |-> (bits_o == '0));

  // R8
  demux_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(!wr_n && !clr_n) && wr_n && clr_n) |-> $onehot0(bits_o));

endmodule

// File: tb/addr_latch8_bench.sv
module addr_latch8_bench;

  localparam int NB = 8;

  logic          clk;
  logic          rst_n;
  logic          din;
  logic [2:0]    sel;
  logic          wr_n;
  logic          clr_n;
  logic [NB-1:0] bits_o;

  int checks;
  int failures;
  logic [NB-1:0] model;
  bit finished;

  addr_latch8 u_addr_latch8 (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (din),
    .sel    (sel),
    .wr_n   (wr_n),
    .clr_n  (clr_n),
    .bits_o (bits_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [NB-1:0] exp);
    checks++;
    if (bits_o !== exp) begin
      failures++;
      $display("FAIL %s: bits_o=%b expected=%b", tag, bits_o, exp);
    end
  endtask

  function automatic logic [NB-1:0] expect_of(input logic w, input logic c,
                                              input logic d, input int s,
                                              input logic [NB-1:0] st);
    logic [NB-1:0] e;
    e = st;
    if (!w && c)       e[s] = d;
    else if (!w && !c) e = d ? (NB'(1) << s) : '0;
    else if (w && !c)  e = '0;
    return e;
  endfunction

  // One cycle: drive at the falling edge, compare before the rising edge,
  // then commit the model at the rising edge.
  task automatic step(input logic w, input logic c, input logic d,
                      input int s, input string tag);
    logic [NB-1:0] e;
    @(negedge clk);
    wr_n = w; clr_n = c; din = d; sel = 3'(s);
    #4;
    e = expect_of(w, c, d, s, model);
    check(tag, e);
    @(posedge clk);
    model = e;
  endtask

  function automatic string tag_of(input logic w, input logic c);
    if (!w && c)  return "R1";
    if (w && c)   return "R2";
    if (!w && !c) return "R3";
    return "R4";
  endfunction

  initial begin
    #(200000 * 20);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] word;
    logic [15:0]   lfsr;
    checks = 0; failures = 0; finished = 0;
    rst_n = 1'b0; din = 1'b0; sel = '0; wr_n = 1'b1; clr_n = 1'b1;
    model = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2 check("R10 reset state", '0);

    // R5: each select value lands on its own bit, sel[0] least significant
    for (int s = 0; s < NB; s++) begin
      step(1'b0, 1'b0, 1'b1, s, "R5 decode position");
    end

    // R9: serial-to-parallel
    word = 8'b1011_0010;
    for (int s = 0; s < NB; s++) step(1'b0, 1'b1, word[s], s, "R9 serial write");
    step(1'b1, 1'b1, 1'b0, 3, "R9 parallel word");
    check("R9 word value", word);

    // R6: kept value is the data at the last write edge
    step(1'b0, 1'b1, 1'b0, 5, "R6 write 0");
    step(1'b1, 1'b1, 1'b1, 5, "R6 hold ignores din");
    check("R6 bit5 kept", word & ~8'b0010_0000);

    // R7: clear committed
    step(1'b1, 1'b0, 1'b1, 2, "R7 clear");
    step(1'b1, 1'b1, 1'b1, 6, "R7 stays clear");
    check("R7 zero", '0);

    // R8: decode pattern stored
    step(1'b0, 1'b1, 1'b1, 0, "R1 preset");
    step(1'b0, 1'b0, 1'b1, 6, "R8 decode");
    step(1'b1, 1'b1, 1'b0, 1, "R8 pattern held");
    check("R8 pattern", 8'b0100_0000);

    // Exhaustive sweep: every mode x select x data, from varying state
    lfsr = 16'hACE1;
    for (int rep = 0; rep < 4; rep++) begin
      for (int m = 0; m < 4; m++) begin
        for (int s = 0; s < NB; s++) begin
          for (int d = 0; d < 2; d++) begin
            logic w, c;
            w = m[0]; c = m[1];
            step(w, c, d[0], s, tag_of(w, c));
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(1'b0, 1'b1, lfsr[0], int'(lfsr[3:1]), "R1 scramble");
          end
        end
      end
    end

    // R10: asynchronous reset without a clock edge
    step(1'b0, 1'b1, 1'b1, 4, "R1 before reset");
    @(negedge clk);
    wr_n = 1'b1; clr_n = 1'b1;
    rst_n = 1'b0;
    #2 check("R10 async clear", '0);
    model = '0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b1, 1'b1, 7, "R10 hold after release");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule